// File: doc/BRIEF.md
# Compressed Page Line Locator

This block turns a cache-line number within a compressed 4KB page into the byte position of that line inside the page's compressed image. Every line of a page is packed into one fixed-size slot, so an ordinary line's position is its index scaled by the slot size. Behind the packed slots sits a 64-byte metadata region with one byte per line. That byte marks lines that did not fit their slot. Such lines are kept at full 64-byte size in an overflow area placed right after the metadata.

A request carries the line number, the page's slot-size code and the line's metadata byte. One cycle after the request is accepted, the block returns three values: the byte offset to read, a flag that says whether the line was redirected to the overflow area, and the number of bytes to fetch. It also returns the offset of the metadata region, so that a memory controller can fetch the metadata byte before it issues the data access. Valid/ready handshakes on both sides allow the output to be stalled.

Top module: `lcp_line_locator`

## Requirements
- R1: After a synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Size code 0 selects 16-byte slots. A line that is not redirected reports offset = line*16 and length 16.
- R3: Size code 1 selects 32-byte slots. A line that is not redirected reports offset = line*32 and length 32.
- R4: Size codes 2 and 3 both mean an uncompressed page. The block reports offset = line*64 and length 64, and the exception flag stays 0 even when bit 7 of the metadata byte is 1.
- R5: out_meta_offset equals 64 times the slot size: 1024, 2048 or 4096.
- R6: When bit 7 of the metadata byte is 1 on a compressed page, out_exception is 1, length is 64, and offset = meta_offset + 64 + idx*64, where idx is metadata bits 5:0.
- R7: Metadata bit 6 has no effect on any output. Bits 5:0 have no effect on a line that is not redirected.
- R8: A request accepted at a clock edge (in_valid and in_ready both 1) gives out_valid = 1 with its result after that same edge. in_ready equals !out_valid || out_ready.
- R9: While out_valid is 1 and out_ready is 0, out_valid and all result outputs hold their values.
- R10: When out_ready stays 1, one request is accepted in every cycle with no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can accept a request |
| in_line | input | 6 | Line index within the page |
| in_size_code | input | 2 | Page slot-size code |
| in_meta | input | 8 | Line metadata byte: bit 7 redirect, bits 5:0 overflow index |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_offset | output | 13 | Byte offset of the line data |
| out_meta_offset | output | 13 | Byte offset of the metadata region |
| out_exception | output | 1 | Line was redirected to the overflow area |
| out_length | output | 7 | Bytes to fetch |

## Verification
The block is driven with ordinary lines at every size code, including the first and last line index. These cases show whether the slot scaling and the metadata base follow the right code. Redirected lines are sent with the lowest and highest overflow index, with bit 6 both set and clear, and on pages that are uncompressed. These cases check that the redirect is gated by page type and that the index scaling is correct. Each pattern is run once with the consumer always ready and once with an irregular ready pattern, which exposes lost, duplicated or drifting results under stalls.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_RAW = 2'd3
  } slot_code_e;

  typedef struct packed {
    logic       redirect;
    logic       spare;
    logic [5:0] idx;
  } meta_entry_t;
endpackage

// File: rtl/lcp_slot_decode.sv
module lcp_slot_decode
  import lcp_pkg::*;
#(
  parameter int MIN_SLOT_LG = 4,
  parameter int SHIFT_W     = 3
) (
  input  logic [1:0]         code,
  output logic [SHIFT_W-1:0] slot_lg,
  output logic               uncompressed
);
  always_comb begin
    unique case (slot_code_e'(code))
      SZ_16:   begin slot_lg = SHIFT_W'(MIN_SLOT_LG);     uncompressed = 1'b0; end
      SZ_32:   begin slot_lg = SHIFT_W'(MIN_SLOT_LG + 1); uncompressed = 1'b0; end
      default: begin slot_lg = SHIFT_W'(MIN_SLOT_LG + 2); uncompressed = 1'b1; end
    endcase
  end
endmodule

// File: rtl/lcp_offset_calc.sv
module lcp_offset_calc
  import lcp_pkg::*;
#(
  parameter int LINE_W  = 6,
  parameter int LB_LG   = 6,
  parameter int SHIFT_W = 3,
  parameter int OFF_W   = 13,
  parameter int LEN_W   = 7
) (
  input  logic [LINE_W-1:0]  line,
  input  logic [SHIFT_W-1:0] slot_lg,
  input  logic               uncompressed,
  input  logic [7:0]         meta,
  output logic [OFF_W-1:0]   offset,
  output logic [OFF_W-1:0]   meta_offset,
  output logic               exception,
  output logic [LEN_W-1:0]   length
);
  localparam logic [OFF_W-1:0] META_BYTES = OFF_W'(1) << LB_LG;

  meta_entry_t          ent;
  logic [OFF_W-1:0]     slot_bytes;
  logic [OFF_W-1:0]     normal_off;
  logic [OFF_W-1:0]     spill_off;

  always_comb begin
    ent         = meta_entry_t'(meta);
    slot_bytes  = OFF_W'(1) << slot_lg;
    meta_offset = slot_bytes << LINE_W;
    normal_off  = OFF_W'(line) << slot_lg;
    spill_off   = meta_offset + META_BYTES + (OFF_W'(ent.idx) << LB_LG);
    exception   = ent.redirect && !uncompressed;
    offset      = exception ? spill_off : normal_off;
    length      = exception ? LEN_W'(1 << LB_LG) : slot_bytes[LEN_W-1:0];
  end
endmodule

// File: rtl/lcp_hold_reg.sv
module lcp_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/lcp_line_locator.sv
module lcp_line_locator #(
  parameter int LINE_W      = 6,
  parameter int LB_LG       = 6,
  parameter int MIN_SLOT_LG = 4,
  parameter int OFF_W       = LINE_W + LB_LG + 1,
  parameter int LEN_W       = LB_LG + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [LINE_W-1:0] in_line,
  input  logic [1:0]       in_size_code,
  input  logic [7:0]       in_meta,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_offset,
  output logic [OFF_W-1:0] out_meta_offset,
  output logic             out_exception,
  output logic [LEN_W-1:0] out_length
);
  localparam int SHIFT_W = 3;
  localparam int RES_W   = 2 * OFF_W + 1 + LEN_W;

  logic [SHIFT_W-1:0] slot_lg;
  logic               uncompressed;
  logic [OFF_W-1:0]   c_off, c_moff;
  logic               c_exc;
  logic [LEN_W-1:0]   c_len;
  logic [RES_W-1:0]   res_d, res_q;

  lcp_slot_decode #(.MIN_SLOT_LG(MIN_SLOT_LG), .SHIFT_W(SHIFT_W)) u_dec (
    .code(in_size_code), .slot_lg(slot_lg), .uncompressed(uncompressed)
  );

  lcp_offset_calc #(
    .LINE_W(LINE_W), .LB_LG(LB_LG), .SHIFT_W(SHIFT_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_calc (
    .line(in_line), .slot_lg(slot_lg), .uncompressed(uncompressed), .meta(in_meta),
    .offset(c_off), .meta_offset(c_moff), .exception(c_exc), .length(c_len)
  );

  assign res_d = {c_off, c_moff, c_exc, c_len};

  lcp_hold_reg #(.W(RES_W)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q)
  );

  assign {out_offset, out_meta_offset, out_exception, out_length} = res_q;
endmodule

// File: rtl/lcp_locator_chk.sv
module lcp_locator_chk #(
  parameter int OFF_W = 13,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFF_W-1:0] out_offset,
  input logic [OFF_W-1:0] out_meta_offset,
  input logic             out_exception,
  input logic [LEN_W-1:0] out_length
);
  // R8
  accept_gives_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_offset) && $stable(out_meta_offset)
                                   && $stable(out_exception) && $stable(out_length)));

  // R5
  meta_base_scale_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_exception) |-> (out_meta_offset == (OFF_W'(out_length) << 6)));

  // R6
  spill_beyond_meta_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_exception) |-> (out_length == LEN_W'(64) && out_offset >= out_meta_offset + OFF_W'(64)));

  // R2
  slot_inside_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_exception) |-> (out_offset < out_meta_offset));

  // R4
  raw_no_spill_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_meta_offset == OFF_W'(4096)) |-> !out_exception);
endmodule

bind lcp_line_locator lcp_locator_chk #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
  .out_meta_offset(out_meta_offset), .out_exception(out_exception), .out_length(out_length)
);

// File: tb/tb_lcp_line_locator.sv
module tb_lcp_line_locator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_line = '0;
  logic [1:0]  in_size_code = '0;
  logic [7:0]  in_meta = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [12:0] out_offset, out_meta_offset;
  logic        out_exception;
  logic [6:0]  out_length;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  int cyc = 0;
  int bubbles = 0;
  logic [32:0] expq[$];
  string       tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcp_line_locator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_line(in_line), .in_size_code(in_size_code), .in_meta(in_meta),
    .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset),
    .out_meta_offset(out_meta_offset), .out_exception(out_exception), .out_length(out_length)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ready pattern changes just after the rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (ready_mode == 0) out_ready = 1'b1;
    else out_ready = ((cyc % 3) != 0) && ((cyc % 7) != 2);
  end

  task automatic send(input int line, input int code, input int meta, input string tag);
    int slot, moff, off, len;
    bit exc;
    slot = (code == 0) ? 16 : (code == 1) ? 32 : 64;
    moff = slot * 64;
    exc  = meta[7] && slot != 64;
    off  = exc ? (moff + 64 + (meta & 63) * 64) : line * slot;
    len  = exc ? 64 : slot;
    in_valid = 1'b1; in_line = 6'(line); in_size_code = 2'(code); in_meta = 8'(meta);
    while (!in_ready) begin
      @(negedge clk);
      if (ready_mode == 0) bubbles++;
    end
    expq.push_back({13'(off), 13'(moff), exc, 6'(len >> 1)});
    tagq.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: compare at the falling edge, transfer happens at the next rising edge
  logic        stalled = 1'b0;
  logic [32:0] held;
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (stalled)
        check({out_offset, out_meta_offset, out_exception, out_length[6:1]} == held,
              "R9 hold under stall", int'(out_offset), int'(held[32:20]));
      if (out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(out_offset), -1);
        end else begin
          logic [32:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          check(out_offset == e[32:20], {t, " offset"}, int'(out_offset), int'(e[32:20]));
          check(out_meta_offset == e[19:7], "R5 meta offset", int'(out_meta_offset), int'(e[19:7]));
          check(out_exception == e[6], {t, " exception"}, int'(out_exception), int'(e[6]));
          check(out_length == {e[5:0], 1'b0}, {t, " length"}, int'(out_length), int'({e[5:0], 1'b0}));
        end
        stalled = 1'b0;
      end else begin
        stalled = 1'b1;
        held = {out_offset, out_meta_offset, out_exception, out_length[6:1]};
      end
    end
  end

  task automatic run_set();
    for (int c = 0; c < 4; c++) begin
      send(0, c, 0, c == 0 ? "R2" : c == 1 ? "R3" : "R4");
      send(63, c, 8'h3f, c == 0 ? "R2" : c == 1 ? "R3" : "R4");
      send(17, c, 8'h40, "R7");
      send(5, c, 8'h80, c >= 2 ? "R4" : "R6");
      send(9, c, 8'hbf, c >= 2 ? "R4" : "R6");
      send(33, c, 8'hc7, c >= 2 ? "R4" : "R7");
      send(42, c, 8'h87, c >= 2 ? "R4" : "R6");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    // R8: single request, result visible after the accepting edge
    send(3, 0, 0, "R2");
    check(out_valid == 1'b1, "R8 latency", int'(out_valid), 1);
    @(negedge clk);
    // R10: back-to-back with consumer always ready
    bubbles = 0;
    run_set();
    check(bubbles == 0, "R10 bubbles", bubbles, 0);
    // stalls: irregular consumer
    ready_mode = 1;
    run_set();
    ready_mode = 0;
    repeat (5) @(negedge clk);
    check(expq.size() == 0, "R9 lost results", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule